// File: doc/BRIEF.md
# Dual Data Pointer Register Unit

This block keeps two 16-bit data pointers for an 8051-compatible core and a one-bit select that names the active one. Every pointer operation the core issues goes to the active pointer: a 16-bit load and an increment. The active pointer is driven out as the address for external data memory. Software can flip between a source and a destination pointer with a single increment of the select register. This removes the need to save and restore addresses during block copies.

The unit sits in the core's special-function-register space. An 8-bit address, a write strobe and write data reach all five of its byte registers. The read side returns the stored byte combinationally, together with a hit flag, so an outer read multiplexer can ignore the unit when the address belongs elsewhere.

The select is held by a two-state machine. The state `SEL_PTR0` routes operations to the first pointer and `SEL_PTR1` routes them to the second. Two transitions exist. `T_TO_PTR1` is taken from `SEL_PTR0` on a select write whose bit 0 is 1. `T_TO_PTR0` is taken from `SEL_PTR1` on a select write whose bit 0 is 0. Any other cycle stays in the current state.

Top module: `dual_ptr_unit`

## Requirements
- R1: After reset both pointers read 0x0000, the select is 0 and `ptr_addr` is 0x0000.
- R2: An SFR write to 0x82/0x83 (first pointer low/high) or 0x84/0x85 (second pointer low/high) changes exactly that byte, whichever pointer is active; other bytes hold.
- R3: The select register is at 0x86. Only bit 0 is stored, and reads return bits 7..1 as zero.
- R4: `ptr_addr` equals the first pointer ({0x83,0x82}) while the select is 0, and the second pointer ({0x85,0x84}) while it is 1.
- R5: Writing the select register with its read value plus one toggles the active pointer (0→0x01 selects the second pointer; 0x01→0x02 selects the first).
- R6: `ptr_inc` adds one to the active pointer, carrying from the low into the high byte and wrapping 0xFFFF to 0x0000; the inactive pointer holds.
- R7: `ptr_load` writes `ptr_load_val` into both bytes of the active pointer only.
- R8: A read of any address outside 0x82..0x86 gives `sfr_hit`=0 and `sfr_rdata`=0x00; addresses in that range give `sfr_hit`=1. Writes outside the range change nothing.
- R9: When an SFR write and a core command hit the same pointer byte in one cycle, that byte takes the SFR data and the other byte takes the command result.
- R10: When `ptr_load` and `ptr_inc` are both high, the load wins.
- R11: A select write in the same cycle as a core command switches the select only after the edge; the command acts on the pointer that was active before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_addr | input | 8 | SFR address for read and write |
| sfr_we | input | 1 | SFR write strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data, zero on a miss |
| sfr_hit | output | 1 | Address belongs to this unit |
| ptr_load | input | 1 | Core command: load the active pointer |
| ptr_load_val | input | 16 | Value for the load command |
| ptr_inc | input | 1 | Core command: increment the active pointer |
| ptr_addr | output | 16 | Active pointer, used as the data memory address |

## Verification
Two functions of this unit can land in the same cycle. The first is an SFR byte write from a software register access. The second is a core pointer command (load or increment) aimed at the same pointer. The bench drives both in one cycle: an increment together with a write to the low byte, and a load together with a write to the high byte. It then reads back both bytes and `ptr_addr` to confirm that the written byte carries the SFR data and the other byte carries the command result. A select write paired with an increment is also driven. This confirms the increment lands on the previously active pointer, while `ptr_addr` shows the newly selected one.

// File: rtl/dptr_pkg.sv
package dptr_pkg;
    localparam int NUM_PTR       = 2;
    localparam int BYTES_PER_PTR = 2;
    localparam int NUM_BYTE_REGS = NUM_PTR * BYTES_PER_PTR;

    typedef enum logic {
        SEL_PTR0 = 1'b0,
        SEL_PTR1 = 1'b1
    } sel_state_e;
endpackage

// File: rtl/dptr_sfr_decode.sv
module dptr_sfr_decode
    import dptr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] PTR_BASE = 8'h82,
    parameter logic [ADDR_W-1:0] SEL_ADDR = 8'h86
) (
    input  logic [ADDR_W-1:0]               addr,
    input  logic [NUM_BYTE_REGS*DATA_W-1:0] bytes_flat,
    input  logic                            sel_bit,
    output logic [NUM_BYTE_REGS-1:0]        byte_hit,
    output logic                            sel_hit,
    output logic                            hit,
    output logic [DATA_W-1:0]               rdata
);
    // Byte k of the flattened pointer storage lives at PTR_BASE + k.
    for (genvar k = 0; k < NUM_BYTE_REGS; k++) begin : g_byte_dec
        assign byte_hit[k] = (addr == PTR_BASE + ADDR_W'(k));
    end

    assign sel_hit = (addr == SEL_ADDR);
    assign hit     = sel_hit | (|byte_hit);

    always_comb begin
        rdata = '0;
        for (int k = 0; k < NUM_BYTE_REGS; k++) begin
            if (byte_hit[k]) begin
                rdata = bytes_flat[k*DATA_W +: DATA_W];
            end
        end
        if (sel_hit) begin
            rdata = {{(DATA_W-1){1'b0}}, sel_bit};
        end
    end
endmodule

// File: rtl/dptr_bank.sv
module dptr_bank #(
    parameter int DATA_W = 8,
    localparam int PW    = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    input  logic              cmd_load,
    input  logic              cmd_inc,
    input  logic [PW-1:0]     load_val,
    output logic [PW-1:0]     value
);
    logic          cmd_en;
    logic [PW-1:0] cmd_val;
    logic [PW-1:0] value_d;

    // Load has priority over increment; SFR byte writes override per byte.
    assign cmd_en  = cmd_load | cmd_inc;
    assign cmd_val = cmd_load ? load_val : value + PW'(1);

    always_comb begin
        value_d = value;
        if (cmd_en) begin
            value_d = cmd_val;
        end
        if (wr_lo) begin
            value_d[DATA_W-1:0] = wdata;
        end
        if (wr_hi) begin
            value_d[PW-1:DATA_W] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= '0;
        end else begin
            value <= value_d;
        end
    end

    // R6: a lone increment adds one with carry and wrap
    p_inc_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_inc && !cmd_load && !wr_lo && !wr_hi) |=> (value == $past(value) + PW'(1)));

    // R10: load wins over a simultaneous increment
    p_load_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_load && !wr_lo && !wr_hi) |=> (value == $past(load_val)));

    // R9: an SFR byte write overrides the command on that byte
    p_sfr_lo_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (value[DATA_W-1:0] == $past(wdata)));

    p_sfr_hi_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> (value[PW-1:DATA_W] == $past(wdata)));

    // R2: with no access at all the pointer holds
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_load || cmd_inc || wr_lo || wr_hi) |=> $stable(value));
endmodule

// File: rtl/dptr_sel_fsm.sv
module dptr_sel_fsm
    import dptr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel_we,
    input  logic sel_wbit,
    output logic sel
);
    sel_state_e state_q;
    sel_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEL_PTR0;
        end else begin
            state_q <= state_d;
        end
    end

    // T_TO_PTR1 / T_TO_PTR0: only bit 0 of a select write matters.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEL_PTR0: if (sel_we && sel_wbit)  state_d = SEL_PTR1;
            SEL_PTR1: if (sel_we && !sel_wbit) state_d = SEL_PTR0;
        endcase
    end

    always_comb begin
        sel = 1'b0;
        unique case (state_q)
            SEL_PTR0: sel = 1'b0;
            SEL_PTR1: sel = 1'b1;
        endcase
    end

    // R5: the select follows bit 0 of each select write
    p_sel_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sel_we |=> (sel == $past(sel_wbit)));

    // R3: without a select write the select holds
    p_sel_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_we |=> $stable(sel));
endmodule

// File: rtl/dual_ptr_unit.sv
module dual_ptr_unit
    import dptr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] PTR_BASE = 8'h82,
    parameter logic [ADDR_W-1:0] SEL_ADDR = 8'h86,
    localparam int PW = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] sfr_addr,
    input  logic              sfr_we,
    input  logic [DATA_W-1:0] sfr_wdata,
    output logic [DATA_W-1:0] sfr_rdata,
    output logic              sfr_hit,
    input  logic              ptr_load,
    input  logic [PW-1:0]     ptr_load_val,
    input  logic              ptr_inc,
    output logic [PW-1:0]     ptr_addr
);
    logic [NUM_BYTE_REGS-1:0]        byte_hit;
    logic                            sel_hit;
    logic                            sel;
    logic [PW-1:0]                   ptr_val [NUM_PTR];
    logic [NUM_BYTE_REGS*DATA_W-1:0] bytes_flat;

    dptr_sfr_decode #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .PTR_BASE(PTR_BASE),
        .SEL_ADDR(SEL_ADDR)
    ) u_decode (
        .addr      (sfr_addr),
        .bytes_flat(bytes_flat),
        .sel_bit   (sel),
        .byte_hit  (byte_hit),
        .sel_hit   (sel_hit),
        .hit       (sfr_hit),
        .rdata     (sfr_rdata)
    );

    dptr_sel_fsm u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_we  (sfr_we & sel_hit),
        .sel_wbit(sfr_wdata[0]),
        .sel     (sel)
    );

    for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
        logic active;
        assign active = (sel == 1'(i));

        dptr_bank #(.DATA_W(DATA_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_lo   (sfr_we & byte_hit[BYTES_PER_PTR*i]),
            .wr_hi   (sfr_we & byte_hit[BYTES_PER_PTR*i+1]),
            .wdata   (sfr_wdata),
            .cmd_load(ptr_load & active),
            .cmd_inc (ptr_inc & active),
            .load_val(ptr_load_val),
            .value   (ptr_val[i])
        );

        assign bytes_flat[i*PW +: PW] = ptr_val[i];
    end

    assign ptr_addr = ptr_val[sel];

    // R8: a miss returns zero read data
    p_miss_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !sfr_hit |-> (sfr_rdata == '0));

    // R3: upper select bits always read as zero
    p_sel_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_addr == SEL_ADDR) |-> (sfr_rdata[DATA_W-1:1] == '0));

    // R6: the inactive second pointer holds when no SFR write occurs
    p_inactive_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel && !sfr_we) |=> $stable(ptr_val[1]));

    p_inactive0_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !sfr_we) |=> $stable(ptr_val[0]));
endmodule

// File: tb/tb_dual_ptr_unit.sv
`timescale 1ns/1ps
module tb_dual_ptr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  sfr_addr = '0;
    logic        sfr_we = 1'b0;
    logic [7:0]  sfr_wdata = '0;
    logic [7:0]  sfr_rdata;
    logic        sfr_hit;
    logic        ptr_load = 1'b0;
    logic [15:0] ptr_load_val = '0;
    logic        ptr_inc = 1'b0;
    logic [15:0] ptr_addr;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    dual_ptr_unit dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sfr_addr    (sfr_addr),
        .sfr_we      (sfr_we),
        .sfr_wdata   (sfr_wdata),
        .sfr_rdata   (sfr_rdata),
        .sfr_hit     (sfr_hit),
        .ptr_load    (ptr_load),
        .ptr_load_val(ptr_load_val),
        .ptr_inc     (ptr_inc),
        .ptr_addr    (ptr_addr)
    );

    typedef struct packed {
        logic [7:0]  addr;
        logic        we;
        logic [7:0]  wd;
        logic        ld;
        logic [15:0] lv;
        logic        inc;
        logic [7:0]  raddr;
        logic [7:0]  erd;
        logic        ehit;
        logic [15:0] eptr;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{8'h82,1'b1,8'h34,1'b0,16'h0000,1'b0, 8'h82,8'h34,1'b1,16'h0034,4'd2}, // R2
        '{8'h83,1'b1,8'h12,1'b0,16'h0000,1'b0, 8'h83,8'h12,1'b1,16'h1234,4'd2}, // R2
        '{8'h84,1'b1,8'hCD,1'b0,16'h0000,1'b0, 8'h84,8'hCD,1'b1,16'h1234,4'd2}, // R2 inactive byte
        '{8'h85,1'b1,8'hAB,1'b0,16'h0000,1'b0, 8'h85,8'hAB,1'b1,16'h1234,4'd2}, // R2
        '{8'h00,1'b0,8'h00,1'b0,16'h0000,1'b1, 8'h82,8'h35,1'b1,16'h1235,4'd6}, // R6
        '{8'h86,1'b1,8'hFF,1'b0,16'h0000,1'b0, 8'h86,8'h01,1'b1,16'hABCD,4'd3}, // R3, R4
        '{8'h00,1'b0,8'h00,1'b0,16'h0000,1'b1, 8'h84,8'hCE,1'b1,16'hABCE,4'd6}, // R6
        '{8'h00,1'b0,8'h00,1'b0,16'h0000,1'b0, 8'h82,8'h35,1'b1,16'hABCE,4'd6}, // R6 inactive held
        '{8'h00,1'b0,8'h00,1'b1,16'hFFFF,1'b0, 8'h85,8'hFF,1'b1,16'hFFFF,4'd7}, // R7
        '{8'h00,1'b0,8'h00,1'b0,16'h0000,1'b1, 8'h84,8'h00,1'b1,16'h0000,4'd6}, // R6 wrap
        '{8'h86,1'b1,8'h02,1'b0,16'h0000,1'b0, 8'h86,8'h00,1'b1,16'h1235,4'd5}, // R5 1+1
        '{8'h86,1'b1,8'h01,1'b0,16'h0000,1'b0, 8'h83,8'h12,1'b1,16'h0000,4'd5}, // R5 0+1
        '{8'h86,1'b1,8'h00,1'b0,16'h0000,1'b0, 8'h86,8'h00,1'b1,16'h1235,4'd4}, // R4
        '{8'h00,1'b0,8'h00,1'b1,16'h00FF,1'b1, 8'h82,8'hFF,1'b1,16'h00FF,4'd10},// R10
        '{8'h82,1'b1,8'h77,1'b0,16'h0000,1'b1, 8'h83,8'h01,1'b1,16'h0177,4'd9}, // R9 inc vs low write
        '{8'h83,1'b1,8'h5A,1'b1,16'hBEEF,1'b0, 8'h82,8'hEF,1'b1,16'h5AEF,4'd9}, // R9 load vs high write
        '{8'h86,1'b1,8'h01,1'b0,16'h0000,1'b1, 8'h82,8'hF0,1'b1,16'h0000,4'd11},// R11
        '{8'h00,1'b0,8'h00,1'b0,16'h0000,1'b0, 8'h81,8'h00,1'b0,16'h0000,4'd8}, // R8 miss read
        '{8'h87,1'b1,8'h55,1'b0,16'h0000,1'b0, 8'h87,8'h00,1'b0,16'h0000,4'd8}, // R8 miss write
        '{8'h86,1'b1,8'hFE,1'b0,16'h0000,1'b0, 8'h86,8'h00,1'b1,16'h5AF0,4'd3}  // R3 bit 0 only
    };

    task automatic chk(input int req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        sfr_we   = 1'b0;
        ptr_load = 1'b0;
        ptr_inc  = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state seen through every register
        #1;
        chk(1, "ptr_addr after reset", ptr_addr, 16'h0000);
        for (int a = 8'h82; a <= 8'h86; a++) begin
            sfr_addr = 8'(a);
            #1;
            chk(1, "register after reset", {8'h00, sfr_rdata}, 16'h0000);
            chk(8, "hit in range", {15'h0, sfr_hit}, 16'h0001);
        end

        // Vector table walk
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            sfr_addr     = VECS[v].addr;
            sfr_we       = VECS[v].we;
            sfr_wdata    = VECS[v].wd;
            ptr_load     = VECS[v].ld;
            ptr_load_val = VECS[v].lv;
            ptr_inc      = VECS[v].inc;
            @(negedge clk);
            idle_inputs();
            sfr_addr = VECS[v].raddr;
            #1;
            chk(int'(VECS[v].req), $sformatf("vec %0d rdata", v), {8'h00, sfr_rdata}, {8'h00, VECS[v].erd});
            chk(int'(VECS[v].req), $sformatf("vec %0d hit", v), {15'h0, sfr_hit}, {15'h0, VECS[v].ehit});
            chk(int'(VECS[v].req), $sformatf("vec %0d ptr_addr", v), ptr_addr, VECS[v].eptr);
        end

        // R4: switch to second pointer, which still holds 0x0000 after the writes above
        @(negedge clk);
        sfr_addr = 8'h86; sfr_we = 1'b1; sfr_wdata = 8'h01;
        @(negedge clk);
        idle_inputs();
        #1;
        chk(4, "second pointer routed", ptr_addr, 16'h0000);
        sfr_addr = 8'h83;
        #1;
        chk(2, "first pointer high intact", {8'h00, sfr_rdata}, 16'h005A);

        // R1: reset in mid-run clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(1, "ptr_addr after second reset", ptr_addr, 16'h0000);
        sfr_addr = 8'h86;
        #1;
        chk(1, "select after second reset", {8'h00, sfr_rdata}, 16'h0000);
        sfr_addr = 8'h83;
        #1;
        chk(1, "first high after second reset", {8'h00, sfr_rdata}, 16'h0000);

        // R10 again at the wrap edge: load beats increment from 0xFFFF
        @(negedge clk);
        ptr_load = 1'b1; ptr_load_val = 16'hFFFF;
        @(negedge clk);
        ptr_load = 1'b1; ptr_load_val = 16'h8000; ptr_inc = 1'b1;
        @(negedge clk);
        idle_inputs();
        #1;
        chk(10, "load over inc", ptr_addr, 16'h8000);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule